// File: doc/BRIEF.md
# Stuck-Cell Pointer Repair for a Memory Line

This block keeps one wide memory line usable after some of its cells have become permanently stuck. Next to the line it holds a small table of repair entries. Each entry records the bit position of a failed cell and a substitute value for that position. A read presents the raw bits fetched from the array. The block returns the line with every repaired position overwritten by its substitute bit. The table is applied from the lowest entry to the highest, so the highest-numbered valid entry for a position decides that bit.

A write presents the data being stored together with a mismatch mask. The mask comes from an external write-verify step; each set bit marks a cell that did not take its value. When the write is accepted, each position already covered by an entry has its deciding entry's substitute bit refreshed from the write data. The block then walks the mask from the lowest set bit upward, one bit per cycle. Each bit takes the next free entry in increasing entry order.

An entry may already point at the same position. The new entry then shadows the old one, which is how a failed repair entry is itself patched. Once all entries are in use the line is reported full. A failure that finds no free entry raises a one-cycle uncorrectable pulse, and the rest of that mask is discarded.

Both the read stream and the write stream use valid/ready. A read is taken when `rd_valid` and `rd_ready` are both high. `rd_ready` is high whenever no response is held or the held response is being taken in the same cycle. A response holds `rsp_valid` and `rsp_data` steady until `rsp_ready` is seen. A write is taken when `wr_valid` and `wr_ready` are both high. `wr_ready` stays low while mask bits from an earlier write are still being processed. Reads continue while a write is being processed.

Top module: `ecp_line_repair`

## Requirements
- R1: After reset, `rsp_valid`, `line_full` and `uncorrectable` are low, `wr_ready` is high and the table is empty, so a read returns its raw bits unchanged.
- R2: A read taken at a clock edge shows `rsp_valid` high after that edge. `rsp_data` then equals the raw bits with each valid entry's substitute bit placed at its pointed index (bit index 0 is the least significant bit). All other bits equal the raw bits.
- R3: While `rsp_valid` is high and `rsp_ready` is low, `rd_ready` is low and `rsp_valid` and `rsp_data` hold their values.
- R4: When a write is taken, every position covered by at least one valid entry has the substitute bit of its highest-numbered entry set to the write data bit at that position. Shadowed older entries keep their values.
- R5: For a write taken with a nonzero mask, `wr_ready` is low from the next cycle. Set mask bits are handled one per cycle from the lowest index upward. Each takes the next unused entry (entry 0 first) with the pointer set to that index and the substitute bit taken from the write data.
- R6: When several valid entries point at one index, the highest-numbered one sets that bit of a read response.
- R7: `line_full` rises when the sixth entry is allocated and then stays high.
- R8: A mask bit that is reached while the line is full pulses `uncorrectable` high for exactly one cycle. The remaining mask bits are discarded, no entry is added or changed by them, and `wr_ready` returns high in that same cycle.
- R9: A read taken at a clock edge is corrected with the table as it stood before that edge. A refresh or allocation made at the same edge is not seen until the next read.
- R10: A write taken with an all-zero mask leaves `wr_ready` high in the following cycle. A write whose mask has k set bits, with enough free entries, keeps `wr_ready` low for exactly k cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Raw line data offered for correction |
| rd_ready | output | 1 | Block can take a read this cycle |
| rd_raw | input | 512 | Raw bits fetched from the array |
| rsp_valid | output | 1 | Corrected line is held on `rsp_data` |
| rsp_ready | input | 1 | Consumer takes the corrected line |
| rsp_data | output | 512 | Corrected line |
| wr_valid | input | 1 | Write data and mismatch mask offered |
| wr_ready | output | 1 | No earlier mask is still being processed |
| wr_data | input | 512 | Data written to the line |
| wr_fail_mask | input | 512 | Verify mismatches, one bit per cell |
| line_full | output | 1 | Every repair entry is in use |
| uncorrectable | output | 1 | One-cycle pulse: a failure found no free entry |

## Verification
A read can be taken at the same clock edge as a write, and at the edge where an allocation from an earlier mask lands. The tests provoke this with one cycle in which both `rd_valid` and `wr_valid` are high against a nonzero mask. The read is held over into the next cycle, where the allocation edge occurs. Before each edge the bench computes the repaired line from its own model of the table, taking care that the model matches the table as it stood before that edge. The first response must show the old substitute values, the second must show the refreshed values without the new entry, and a later read must show the new entry.

// File: rtl/ecp_pkg.sv
package ecp_pkg;
  // Default geometry of one protected line.
  parameter int unsigned LINE_BITS_DEF = 512;
  parameter int unsigned ENTRIES_DEF   = 6;
endpackage

// File: rtl/ecp_fail_picker.sv
// Finds the lowest set bit of a pending mismatch mask.
module ecp_fail_picker #(
  parameter int unsigned W  = ecp_pkg::LINE_BITS_DEF,
  localparam int unsigned PW = $clog2(W)
) (
  input  logic [W-1:0]  mask,
  output logic          any,
  output logic [PW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (mask[i]) idx = PW'(i);
    end
  end

  assign any = |mask;
endmodule

// File: rtl/ecp_patch_net.sv
// Overlays substitute bits on raw data, lowest entry first.
module ecp_patch_net #(
  parameter int unsigned W  = ecp_pkg::LINE_BITS_DEF,
  parameter int unsigned N  = ecp_pkg::ENTRIES_DEF,
  localparam int unsigned PW = $clog2(W)
) (
  input  logic [W-1:0]         raw,
  input  logic [N-1:0]         ent_valid,
  input  logic [N-1:0][PW-1:0] ent_ptr,
  input  logic [N-1:0]         ent_repl,
  output logic [W-1:0]         fixed
);
  always_comb begin
    fixed = raw;
    for (int i = 0; i < N; i++) begin
      if (ent_valid[i]) fixed[ent_ptr[i]] = ent_repl[i];
    end
  end
endmodule

// File: rtl/ecp_entry_table.sv
// Holds the repair entries: in-order allocation and substitute refresh.
module ecp_entry_table #(
  parameter int unsigned W  = ecp_pkg::LINE_BITS_DEF,
  parameter int unsigned N  = ecp_pkg::ENTRIES_DEF,
  localparam int unsigned PW = $clog2(W),
  localparam int unsigned CW = $clog2(N + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 refresh_en,
  input  logic [W-1:0]         refresh_data,
  input  logic                 alloc_en,
  input  logic [PW-1:0]        alloc_ptr,
  input  logic                 alloc_bit,
  output logic [N-1:0]         ent_valid,
  output logic [N-1:0][PW-1:0] ent_ptr,
  output logic [N-1:0]         ent_repl,
  output logic                 full
);
  logic [CW-1:0] used_q;
  logic [N-1:0]  owner;

  // An entry owns its position when no later valid entry shares the pointer.
  for (genvar gi = 0; gi < N; gi++) begin : g_owner
    logic shadowed;
    always_comb begin
      shadowed = 1'b0;
      for (int j = gi + 1; j < N; j++) begin
        if (ent_valid[j] && (ent_ptr[j] == ent_ptr[gi])) shadowed = 1'b1;
      end
    end
    assign owner[gi] = ent_valid[gi] && !shadowed;
  end

  assign full = (used_q == CW'(N));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_q    <= '0;
      ent_valid <= '0;
      ent_ptr   <= '0;
      ent_repl  <= '0;
    end else begin
      if (refresh_en) begin
        for (int i = 0; i < N; i++) begin
          if (owner[i]) ent_repl[i] <= refresh_data[ent_ptr[i]];
        end
      end
      if (alloc_en && !full) begin
        for (int i = 0; i < N; i++) begin
          if (used_q == CW'(i)) begin
            ent_valid[i] <= 1'b1;
            ent_ptr[i]   <= alloc_ptr;
            ent_repl[i]  <= alloc_bit;
          end
        end
        used_q <= used_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/ecp_line_repair.sv
// Top: read correction stream plus write-side failure allocation.
module ecp_line_repair #(
  parameter int unsigned LINE_W  = ecp_pkg::LINE_BITS_DEF,
  parameter int unsigned ENTRIES = ecp_pkg::ENTRIES_DEF,
  localparam int unsigned PW = $clog2(LINE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [LINE_W-1:0] rd_raw,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [LINE_W-1:0] rsp_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [LINE_W-1:0] wr_data,
  input  logic [LINE_W-1:0] wr_fail_mask,
  output logic              line_full,
  output logic              uncorrectable
);
  logic [LINE_W-1:0]          pend_mask_q, pend_data_q, fixed;
  logic [ENTRIES-1:0]         ent_valid, ent_repl;
  logic [ENTRIES-1:0][PW-1:0] ent_ptr;
  logic [PW-1:0]              fail_idx;
  logic                       fail_any, full, wr_fire, rd_fire, alloc_en, drop;

  assign wr_ready  = !fail_any;
  assign wr_fire   = wr_valid && wr_ready;
  assign rd_ready  = !rsp_valid || rsp_ready;
  assign rd_fire   = rd_valid && rd_ready;
  assign alloc_en  = fail_any && !full;
  assign drop      = fail_any && full;
  assign line_full = full;

  ecp_fail_picker #(.W(LINE_W)) u_pick (
    .mask (pend_mask_q),
    .any  (fail_any),
    .idx  (fail_idx)
  );

  ecp_entry_table #(.W(LINE_W), .N(ENTRIES)) u_table (
    .clk          (clk),
    .rst_n        (rst_n),
    .refresh_en   (wr_fire),
    .refresh_data (wr_data),
    .alloc_en     (alloc_en),
    .alloc_ptr    (fail_idx),
    .alloc_bit    (pend_data_q[fail_idx]),
    .ent_valid    (ent_valid),
    .ent_ptr      (ent_ptr),
    .ent_repl     (ent_repl),
    .full         (full)
  );

  ecp_patch_net #(.W(LINE_W), .N(ENTRIES)) u_patch (
    .raw       (rd_raw),
    .ent_valid (ent_valid),
    .ent_ptr   (ent_ptr),
    .ent_repl  (ent_repl),
    .fixed     (fixed)
  );

  // Pending failure walk: one mask bit per cycle, lowest first.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_mask_q   <= '0;
      pend_data_q   <= '0;
      uncorrectable <= 1'b0;
    end else begin
      uncorrectable <= drop;
      if (wr_fire) begin
        pend_mask_q <= wr_fail_mask;
        pend_data_q <= wr_data;
      end else if (alloc_en) begin
        pend_mask_q <= pend_mask_q & ~(LINE_W'(1) << fail_idx);
      end else if (drop) begin
        pend_mask_q <= '0;
      end
    end
  end

  // Registered read response with back-pressure.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
      rsp_data  <= fixed;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ecp_line_repair_chk.sv
module ecp_line_repair_chk #(
  parameter int unsigned LINE_W = 512
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [LINE_W-1:0] rd_raw,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [LINE_W-1:0] rsp_data,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [LINE_W-1:0] wr_data,
  input logic [LINE_W-1:0] wr_fail_mask,
  input logic              line_full,
  input logic              uncorrectable
);
  p_rsp_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready |=> rsp_valid);

  p_rsp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  p_stall_blocks_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !rd_ready);

  p_busy_after_fail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && (|wr_fail_mask) |=> !wr_ready);

  p_full_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_full |=> line_full);

  p_uncorr_needs_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    uncorrectable |-> line_full && wr_ready);

  p_uncorr_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    uncorrectable |=> !uncorrectable);

  p_idle_no_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && !(|wr_fail_mask) |=> wr_ready);
endmodule

bind ecp_line_repair ecp_line_repair_chk #(.LINE_W(LINE_W)) u_chk (.*);

// File: tb/test_ecp_line_repair.sv
module test_ecp_line_repair;
  localparam int W = 512;
  localparam int N = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_valid = 1'b0, rsp_ready = 1'b1, wr_valid = 1'b0;
  logic [W-1:0] rd_raw = '0, wr_data = '0, wr_fail_mask = '0;
  logic rd_ready, rsp_valid, wr_ready, line_full, uncorrectable;
  logic [W-1:0] rsp_data;

  int checks = 0, errors = 0;

  // Bench model of the repair table.
  int         m_cnt = 0;
  logic [8:0] m_ptr [N];
  logic       m_rep [N];

  always #2 clk = ~clk;

  ecp_line_repair i_ecp_line_repair (.*);

  task automatic check_vec(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_bit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic check_int(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model_read(logic [W-1:0] raw);
    logic [W-1:0] r = raw;
    for (int i = 0; i < m_cnt; i++) r[m_ptr[i]] = m_rep[i];
    return r;
  endfunction

  function automatic void model_refresh(logic [W-1:0] data);
    for (int i = 0; i < m_cnt; i++) begin
      bit shadow = 1'b0;
      for (int j = i + 1; j < m_cnt; j++) if (m_ptr[j] == m_ptr[i]) shadow = 1'b1;
      if (!shadow) m_rep[i] = data[m_ptr[i]];
    end
  endfunction

  // Returns number of busy cycles; sets unc when a failure is dropped.
  function automatic int model_alloc(logic [W-1:0] data, logic [W-1:0] mask, output bit unc);
    int busy = 0;
    unc = 1'b0;
    for (int b = 0; b < W; b++) begin
      if (mask[b]) begin
        busy++;
        if (m_cnt < N) begin
          m_ptr[m_cnt] = 9'(b);
          m_rep[m_cnt] = data[b];
          m_cnt++;
        end else begin
          unc = 1'b1;
          break;
        end
      end
    end
    return busy;
  endfunction

  task automatic do_write(string req, logic [W-1:0] data, logic [W-1:0] mask);
    bit unc;
    int exp_busy, n;
    model_refresh(data);
    exp_busy = model_alloc(data, mask, unc);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = data; wr_fail_mask = mask;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0; wr_fail_mask = '0;
    n = 0;
    while (!wr_ready && n < 40) begin
      n++;
      @(negedge clk);
    end
    check_int({req, " busy cycles"}, n, exp_busy);
    check_bit({req, " uncorrectable pulse"}, uncorrectable, unc);
    if (unc) begin
      @(negedge clk);
      check_bit({req, " uncorrectable one cycle"}, uncorrectable, 1'b0);
    end
  endtask

  task automatic do_read(string req, logic [W-1:0] raw);
    @(negedge clk);
    rd_valid = 1'b1; rd_raw = raw; rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_valid = 1'b0;
    check_bit({req, " rsp_valid"}, rsp_valid, 1'b1);
    check_vec({req, " data"}, rsp_data, model_read(raw));
  endtask

  task automatic t_reset_r1;
    check_bit("R1 rsp_valid", rsp_valid, 1'b0);
    check_bit("R1 wr_ready", wr_ready, 1'b1);
    check_bit("R1 line_full", line_full, 1'b0);
    check_bit("R1 uncorrectable", uncorrectable, 1'b0);
    do_read("R1 raw passthrough", {16{32'hA5A5_0F0F}});
  endtask

  task automatic t_alloc_r5;
    logic [W-1:0] m = '0;
    m[3] = 1'b1; m[500] = 1'b1;
    do_write("R5 R10 two failures", '1, m);
    do_read("R5 R2 corrected read", '0);
    do_read("R2 patterned read", {16{32'h1234_5678}});
    check_bit("R7 not full", line_full, 1'b0);
    do_write("R10 empty mask", {16{32'hFFFF_0000}}, '0);
  endtask

  task automatic t_refresh_r4;
    do_write("R4 refresh zeros", '0, '0);
    do_read("R4 refreshed read", '1);
  endtask

  task automatic t_override_r6;
    logic [W-1:0] m = '0;
    m[3] = 1'b1;
    do_write("R6 patch entry", '1, m);
    do_write("R6 R4 newest refreshed", '0, '0);
    do_read("R6 newest wins", '1);
  endtask

  task automatic t_same_cycle_r9;
    logic [W-1:0] raw = {16{32'h0F0F_3C3C}};
    logic [W-1:0] d = '1;
    logic [W-1:0] m = '0;
    logic [W-1:0] exp_a, exp_b;
    bit unc;
    int busy;
    m[100] = 1'b1;
    d[100] = 1'b0;
    exp_a = model_read(raw);
    model_refresh(d);
    exp_b = model_read(raw);
    busy = model_alloc(d, m, unc);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d; wr_fail_mask = m;
    rd_valid = 1'b1; rd_raw = raw; rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0; wr_fail_mask = '0;
    check_bit("R5 busy during alloc", wr_ready, 1'b0);
    check_vec("R9 read with write edge", rsp_data, exp_a);
    @(posedge clk);
    @(negedge clk);
    rd_valid = 1'b0;
    check_vec("R9 read with alloc edge", rsp_data, exp_b);
    check_bit("R10 ready after one", wr_ready, 1'b1);
    check_int("R9 model busy", busy, 1);
    do_read("R9 alloc visible later", raw);
  endtask

  task automatic t_backpressure_r3;
    logic [W-1:0] r1 = {16{32'hDEAD_BEEF}};
    logic [W-1:0] r2 = {16{32'h5555_AAAA}};
    @(negedge clk);
    rsp_ready = 1'b0; rd_valid = 1'b1; rd_raw = r1;
    @(posedge clk);
    @(negedge clk);
    rd_raw = r2;
    for (int k = 0; k < 3; k++) begin
      check_bit("R3 rd_ready low", rd_ready, 1'b0);
      check_bit("R3 rsp_valid held", rsp_valid, 1'b1);
      check_vec("R3 data held", rsp_data, model_read(r1));
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_valid = 1'b0;
    check_vec("R3 next after release", rsp_data, model_read(r2));
    @(posedge clk);
    @(negedge clk);
    check_bit("R3 drained", rsp_valid, 1'b0);
  endtask

  task automatic t_full_r8;
    logic [W-1:0] m = '0;
    logic [W-1:0] d = {16{32'h0000_0A80}};
    m[7] = 1'b1; m[9] = 1'b1; m[11] = 1'b1;
    d[11] = 1'b0;
    do_write("R8 fill and overflow", d, m);
    check_bit("R7 full", line_full, 1'b1);
    do_read("R8 table unchanged", '1);
    m = '0; m[20] = 1'b1;
    do_write("R8 failure when full", '0, m);
    check_bit("R7 stays full", line_full, 1'b1);
    do_read("R8 R6 final read", {16{32'hC3C3_9696}});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r1();
    t_alloc_r5();
    t_refresh_r4();
    t_override_r6();
    t_same_cycle_r9();
    t_backpressure_r3();
    t_full_r8();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule